// File: doc/BRIEF.md
# EEPROM Status and Write-Guard Unit

This unit holds the status byte of a small serial EEPROM and decides whether each write request may go ahead. A command decoder in front of it supplies single-cycle strobes: arm writes, disarm writes, load status (with a data byte), start a data write (with the target address), and end of the internal write cycle. A hardware lock pin, active low, can veto every write regardless of the software state.

The status byte carries a busy flag, a write-armed flag and a two-bit protection level. The write permit output is high only when the unit is idle, armed, the lock pin is high and the target address lies outside the protected range chosen by the protection level. An accepted write or status load raises the busy flag until the end-of-cycle strobe arrives. That strobe clears both busy and armed. A rejected request also clears armed. The protection level is an ordinary register that reset returns to zero.

Top module: `eep_status_guard`

## Requirements
- R1: After reset, status_o is 8'h00 and wr_permit_o is 0.
- R2: While idle, arm_i sets status bit 1 (armed) on the next cycle and disarm_i clears it on the next cycle.
- R3: The status layout is bit 0 = busy, bit 1 = armed, bits 3:2 = protection level. Bits 7:4 always read 0.
- R4: sr_wr_i while idle, armed and with lock_n_i high loads sr_din_i[3:2] into the protection level and sets busy on the next cycle. The other bits of sr_din_i are ignored. sr_wr_i while not armed leaves the protection level unchanged and does not set busy.
- R5: Protection level 00 blocks no address, 01 blocks addresses 96 to 127, 10 blocks 64 to 127 and 11 blocks all addresses. wr_permit_o is 0 for a blocked address.
- R6: While lock_n_i is low, wr_permit_o is 0. An sr_wr_i in that state is rejected: the protection level is unchanged and armed clears.
- R7: wr_go_i while wr_permit_o is 1 sets busy on the next cycle. wr_go_i while idle with wr_permit_o at 0 leaves busy at 0 and clears armed.
- R8: cyc_done_i while busy clears both busy and armed on the next cycle.
- R9: While busy, wr_permit_o is 0 and arm_i, disarm_i, sr_wr_i and wr_go_i have no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm-writes command strobe |
| disarm_i | input | 1 | Disarm-writes command strobe |
| sr_wr_i | input | 1 | Load-status command strobe |
| sr_din_i | input | 8 | Data byte for the load-status command |
| wr_go_i | input | 1 | Start-data-write strobe |
| wr_addr_i | input | 7 | Target address of the data write |
| cyc_done_i | input | 1 | End of the internal write cycle |
| lock_n_i | input | 1 | Hardware write lock, writes blocked when low |
| status_o | output | 8 | Status byte for a status read |
| wr_permit_o | output | 1 | Write to wr_addr_i is allowed |

## Verification
The assertions take for granted that the decoder raises at most one of the five command strobes in any cycle, and that the end-of-cycle strobe follows only an accepted write; one of them checks the first of these as an input rule. The bench drives each strobe alone for exactly one cycle, changing inputs on the falling clock edge, and issues the end-of-cycle strobe only while busy is showing. The protection decode is swept at the addresses on both sides of each range boundary for all four levels.

// File: rtl/eep_sr_pkg.sv
package eep_sr_pkg;

  localparam int SR_W     = 8;
  localparam int BUSY_BIT = 0;
  localparam int ARM_BIT  = 1;
  localparam int LVL_LO   = 2;
  localparam int LVL_W    = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // Address hit test for a protection level; the top two address bits
  // select the quarter of the array.
  function automatic logic lvl_hit(input lvl_t lvl, input logic [1:0] top2);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [SR_W-1:0] pack_status(input logic busy,
                                                  input logic armed,
                                                  input lvl_t lvl);
    logic [SR_W-1:0] s;
    s = '0;
    s[BUSY_BIT] = busy;
    s[ARM_BIT]  = armed;
    s[LVL_LO +: LVL_W] = lvl;
    return s;
  endfunction

endpackage

// File: rtl/eep_arm_latch.sv
module eep_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_o <= 1'b0;
    else if (clr_i)  armed_o <= 1'b0;
    else if (set_i)  armed_o <= 1'b1;
  end
endmodule

// File: rtl/eep_busy_flag.sv
module eep_busy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic busy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_o <= 1'b0;
    else if (end_i)    busy_o <= 1'b0;
    else if (start_i)  busy_o <= 1'b1;
  end
endmodule

// File: rtl/eep_lvl_reg.sv
module eep_lvl_reg
  import eep_sr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  lvl_t lvl_i,
  output lvl_t lvl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_o <= '0;
    else if (load_i) lvl_o <= lvl_i;
  end
endmodule

// File: rtl/eep_status_guard.sv
module eep_status_guard
  import eep_sr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_din_i,
  input  logic              wr_go_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              cyc_done_i,
  input  logic              lock_n_i,
  output logic [SR_W-1:0]   status_o,
  output logic              wr_permit_o
);

  logic busy, armed;
  lvl_t lvl;

  // Named internal events
  logic idle, sw_ok, addr_hit;
  logic arm_set, arm_clr, sr_take, wr_take, reject, cyc_end, busy_start;

  assign idle     = !busy;
  assign sw_ok    = armed && lock_n_i;
  assign addr_hit = lvl_hit(lvl, wr_addr_i[ADDR_W-1 -: 2]);

  assign wr_permit_o = idle && sw_ok && !addr_hit;

  assign sr_take    = sr_wr_i && idle && sw_ok;
  assign wr_take    = wr_go_i && wr_permit_o;
  assign reject     = idle && ((sr_wr_i && !sw_ok) || (wr_go_i && !wr_permit_o));
  assign cyc_end    = cyc_done_i && busy;
  assign busy_start = sr_take || wr_take;
  assign arm_set    = arm_i && idle;
  assign arm_clr    = (disarm_i && idle) || reject || cyc_end;

  eep_arm_latch u_arm (
    .clk(clk), .rst_n(rst_n), .set_i(arm_set), .clr_i(arm_clr), .armed_o(armed)
  );

  eep_busy_flag u_busy (
    .clk(clk), .rst_n(rst_n), .start_i(busy_start), .end_i(cyc_end), .busy_o(busy)
  );

  eep_lvl_reg u_lvl (
    .clk(clk), .rst_n(rst_n), .load_i(sr_take),
    .lvl_i(sr_din_i[LVL_LO +: LVL_W]), .lvl_o(lvl)
  );

  assign status_o = pack_status(busy, armed, lvl);

  // Input rule: decoder raises at most one strobe per cycle (R9 context)
  a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_i, disarm_i, sr_wr_i, wr_go_i, cyc_done_i}));

  a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n_i |-> !wr_permit_o);

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BUSY_BIT] |-> !wr_permit_o);

  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !status_o[BUSY_BIT]) |=> status_o[ARM_BIT]);

  a_r7_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go_i && wr_permit_o) |=> status_o[BUSY_BIT]);

  a_r7_reject_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go_i && !wr_permit_o && !status_o[BUSY_BIT])
      |=> (!status_o[ARM_BIT] && !status_o[BUSY_BIT]));

  a_r8_done_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_i && status_o[BUSY_BIT]) |=> (status_o[1:0] == 2'b00));

  a_r9_lvl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BUSY_BIT] |=> $stable(status_o[LVL_LO +: LVL_W]));

  a_r4_lvl_load: assert property (@(posedge clk) disable iff (!rst_n)
    sr_take |=> (status_o[LVL_LO +: LVL_W] == $past(sr_din_i[LVL_LO +: LVL_W])));

endmodule

// File: tb/eep_status_guard_test.sv
module eep_status_guard_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_i = 0, disarm_i = 0, sr_wr_i = 0, wr_go_i = 0, cyc_done_i = 0;
  logic [7:0] sr_din_i = 8'h00;
  logic [6:0] wr_addr_i = 7'd0;
  logic       lock_n_i = 1'b1;
  logic [7:0] status_o;
  logic       wr_permit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eep_status_guard uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
    .sr_wr_i(sr_wr_i), .sr_din_i(sr_din_i), .wr_go_i(wr_go_i),
    .wr_addr_i(wr_addr_i), .cyc_done_i(cyc_done_i), .lock_n_i(lock_n_i),
    .status_o(status_o), .wr_permit_o(wr_permit_o)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic blocked(int lvl, int a);
    if (lvl == 3) return 1'b1;
    if (lvl == 2) return a >= 64;
    if (lvl == 1) return a >= 96;
    return 1'b0;
  endfunction

  // One-cycle strobe: drive on falling edge, release on the next falling edge
  task automatic pulse(string which);
    @(negedge clk);
    case (which)
      "arm":    arm_i = 1;
      "disarm": disarm_i = 1;
      "sr":     sr_wr_i = 1;
      "go":     wr_go_i = 1;
      "done":   cyc_done_i = 1;
      default:  ;
    endcase
    @(negedge clk);
    arm_i = 0; disarm_i = 0; sr_wr_i = 0; wr_go_i = 0; cyc_done_i = 0;
  endtask

  task automatic set_lvl(logic [1:0] l);
    pulse("arm");
    sr_din_i = {4'h0, l, 2'b00};
    pulse("sr");
    pulse("done");
  endtask

  task automatic t_reset;
    check8("R1 status", status_o, 8'h00);
    check8("R1 permit", {7'b0, wr_permit_o}, 8'h00);
  endtask

  task automatic t_arm;
    pulse("arm");
    check8("R2 arm", status_o, 8'h02);
    pulse("disarm");
    check8("R2 disarm", status_o, 8'h00);
  endtask

  task automatic t_sr_write;
    sr_din_i = 8'hF5;            // bits 3:2 = 01, rest ignored
    pulse("sr");
    check8("R4 unarmed load", status_o, 8'h00);
    pulse("arm");
    pulse("sr");
    check8("R4 R3 load", status_o, 8'h07);
    pulse("disarm");
    check8("R9 disarm busy", status_o, 8'h07);
    wr_addr_i = 7'd5;
    check8("R9 permit busy", {7'b0, wr_permit_o}, 8'h00);
    pulse("go");
    check8("R9 go busy", status_o, 8'h07);
    sr_din_i = 8'h0C;
    pulse("sr");
    check8("R9 sr busy", status_o, 8'h07);
    pulse("done");
    check8("R8 done", status_o, 8'h04);
  endtask

  task automatic t_decode;
    int addrs[6] = '{0, 63, 64, 95, 96, 127};
    for (int l = 0; l < 4; l++) begin
      set_lvl(l[1:0]);
      pulse("arm");
      for (int k = 0; k < 6; k++) begin
        wr_addr_i = addrs[k][6:0];
        #1;
        check8($sformatf("R5 lvl%0d addr%0d", l, addrs[k]),
               {7'b0, wr_permit_o}, {7'b0, !blocked(l, addrs[k])});
      end
      lock_n_i = 0;
      wr_addr_i = 7'd0;
      #1;
      check8("R6 lock permit", {7'b0, wr_permit_o}, 8'h00);
      lock_n_i = 1;
      pulse("disarm");
    end
  endtask

  task automatic t_write;
    set_lvl(2'b01);
    pulse("arm");
    wr_addr_i = 7'd10;
    pulse("go");
    check8("R7 accept", status_o, 8'h07);
    pulse("done");
    check8("R8 done write", status_o, 8'h04);
    pulse("arm");
    wr_addr_i = 7'd100;
    pulse("go");
    check8("R7 reject", status_o, 8'h04);
  endtask

  task automatic t_lock;
    set_lvl(2'b10);
    pulse("arm");
    @(negedge clk);
    lock_n_i = 0;
    sr_din_i = 8'h00;
    pulse("sr");
    check8("R6 lock sr", status_o, 8'h08);
    lock_n_i = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_sr_write();
    t_decode();
    t_write();
    t_lock();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule